// File: doc/BRIEF.md
# Configurable Serial Data Streaming Master

This block is a transmit-only serial master. It sends a burst of 32-bit measurement words to an external synchronous receiver, such as an SPI slave or a frame-synchronised serial port. It drives three lines: a serial clock, a serial data line and a frame-select line. The parallel bank of sixteen 32-bit words comes from elsewhere in the chip.

An 8-bit configuration byte sets five things: the serial clock rate, whether a word goes out as one 32-bit package or as four byte packages, an optional idle gap between packages, which group of words a burst carries, and the active level of the select line. A separate port-enable input arms the port. Each trigger pulse that arrives while the port is armed and idle copies the selected words and the configuration into a shadow store. The burst is then shifted out of that copy, so inputs that change mid-transfer cannot tear the burst. A busy output covers the whole burst.

Bank slot layout used by the reduced sets: slots 0..5 hold the current/voltage samples in the order Ia, Va, Ib, Vb, Ic, Vc. Slots 6..11 hold apparent power A, B, C, then active power A, B, C.

Top module: `stream_tx_master`

## Requirements
- R1: During and after reset, the serial clock, data and select outputs are all high and busy is low. The shadow configuration resets to zero, which means the select line is active low.
- R2: A trigger sampled high while the port is enabled and busy is low starts a burst. On the next cycle busy is high, the serial clock is low, select is active and data carries bit 31 of the first word. A trigger sampled while the port is disabled has no effect.
- R3: Configuration bit 0 sets the bit cell length: 0 gives 2 system cycles and 1 gives 4. In every cell the serial clock is low for the first half and high for the second half. It idles high.
- R4: The data line changes only at the start of a bit cell, when the serial clock falls. It is stable while the serial clock is high inside a package. Words go out most significant bit first.
- R5: Configuration bits 4:3 select the words of a burst. 2'b00 sends slots 0..15 in order. 2'b01 sends slots 0..5 and then one zero word. 2'b10 sends slots 6..11 and then three zero words. 2'b11 behaves as 2'b00.
- R6: When configuration bit 2 is 1, the block idles for 7 bit cells between packages and never after the last one. During a gap, clock and data are high and select is inactive. Configuration bit 1 sets the package size: 0 gives 32-bit packages and 1 gives 8-bit packages.
- R7: When configuration bit 2 is 0, bits follow back to back with no gap. Configuration bit 1 then has no effect on timing.
- R8: Configuration bit 5 sets the select active level (1 means active high). Select is active during exactly the bit cells that carry data. It is inactive in gaps and between bursts.
- R9: Busy stays high for exactly D*(32*N + 7*G) cycles. D is the cell length, N is the word count and G is the number of gaps.
- R10: A trigger that arrives while busy is ignored. The running burst keeps its length, and no second burst follows.
- R11: The words and the configuration are captured at the start trigger. Changes to them during a burst do not alter that burst.
- R12: Configuration bits 7:6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 8 | Configuration byte |
| port_en_i | input | 1 | Port enable; arms the trigger |
| trig_i | input | 1 | Burst start pulse |
| words_i | input | 512 | Sixteen 32-bit words, slot k at bits [32k+31:32k] |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| sel_o | output | 1 | Frame select, polarity from configuration |
| busy_o | output | 1 | High while a burst is in progress |

## Verification
The first serial results appear one system cycle after the edge that samples the trigger. At that cycle busy, the falling serial clock, the active select and the first data bit must all be present, and the bench checks them at the following falling system-clock edge. Each data bit is sampled at the cycle where the serial clock is seen to rise, which is D/2 cycles into its cell. Busy length and select-active cycle counts are compared with the D*(32*N + 7*G) formula only after busy has fallen. Idle levels are read at that same half-cycle point, and all samples are taken half a system clock away from the edges that move the design.

// File: rtl/stx_pkg.sv
`timescale 1ns/1ps
package stx_pkg;

  // Reduced transfer sets: six words plus zero padding
  localparam int unsigned GRP_N   = 6;
  localparam int unsigned CV_PAD  = 1;
  localparam int unsigned PWR_PAD = 3;

  // Configuration byte layout (first field is the most significant)
  typedef struct packed {
    logic [1:0] rsvd;      // [7:6] no function
    logic       sel_high;  // [5]   select active level
    logic [1:0] set_sel;   // [4:3] transfer set
    logic       gap_en;    // [2]   idle cells between packages
    logic       byte_pkg;  // [1]   8-bit packages
    logic       slow_clk;  // [0]   long bit cell
  } stx_cfg_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_GAP   = 2'd2
  } sq_state_e;

  // Number of words a burst carries for a given set code
  function automatic int unsigned burst_words(input logic [1:0] set_sel,
                                              input int unsigned bank_n);
    case (set_sel)
      2'b01:   return GRP_N + CV_PAD;
      2'b10:   return GRP_N + PWR_PAD;
      default: return bank_n;
    endcase
  endfunction

  // True on the last bit of a package
  function automatic logic pkg_last(input logic byte_pkg,
                                    input int unsigned bit_idx,
                                    input int unsigned pkg_w,
                                    input int unsigned word_w);
    if (byte_pkg)
      return (bit_idx % pkg_w) == (pkg_w - 1);
    return bit_idx == (word_w - 1);
  endfunction

endpackage

// File: rtl/stx_cellclk.sv
`timescale 1ns/1ps
// Bit-cell timer: divides the system clock into serial bit cells.
module stx_cellclk #(
  parameter int unsigned FAST_DIV = 2,
  parameter int unsigned SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic cell_end,
  output logic low_half
);
  localparam int unsigned PH_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] last_ph;
  logic [PH_W-1:0] half_ph;

  assign last_ph  = slow ? PH_W'(SLOW_DIV - 1) : PH_W'(FAST_DIV - 1);
  assign half_ph  = slow ? PH_W'(SLOW_DIV / 2) : PH_W'(FAST_DIV / 2);
  assign cell_end = run && (ph_q == last_ph);
  assign low_half = run && (ph_q < half_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ph_q <= '0;
    else if (!run || cell_end)
      ph_q <= '0;
    else
      ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/stx_shadow.sv
`timescale 1ns/1ps
// Shadow store: picks the words of the selected set at trigger time
// and holds them with the configuration for the whole burst.
module stx_shadow
  import stx_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned BANK_N   = 16,
  parameter int unsigned CV_BASE  = 0,
  parameter int unsigned PWR_BASE = 6,
  parameter int unsigned IDX_W    = $clog2(BANK_N),
  parameter int unsigned CNT_W    = $clog2(BANK_N + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic [7:0]               cfg_i,
  input  logic [BANK_N*WORD_W-1:0] words_i,
  input  logic [IDX_W-1:0]         rd_idx,
  output stx_cfg_t                 cfg_q,
  output logic [CNT_W-1:0]         n_words_q,
  output logic [WORD_W-1:0]        rd_word
);
  stx_cfg_t          cfg_in;
  logic [WORD_W-1:0] slot_w [BANK_N];

  assign cfg_in = stx_cfg_t'(cfg_i);

  for (genvar s = 0; s < BANK_N; s++) begin : g_slot
    localparam int unsigned CV_IDX = (s < GRP_N) ? CV_BASE + s : 0;
    localparam int unsigned PW_IDX = (s < GRP_N) ? PWR_BASE + s : 0;
    localparam bit IN_GRP = (s < GRP_N);

    logic [WORD_W-1:0] pick;
    logic [WORD_W-1:0] slot_q;

    always_comb begin
      case (cfg_in.set_sel)
        2'b01:   pick = IN_GRP ? words_i[CV_IDX*WORD_W +: WORD_W] : '0;
        2'b10:   pick = IN_GRP ? words_i[PW_IDX*WORD_W +: WORD_W] : '0;
        default: pick = words_i[s*WORD_W +: WORD_W];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= '0;
      else if (capture)
        slot_q <= pick;
    end

    assign slot_w[s] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      n_words_q <= '0;
    end else if (capture) begin
      cfg_q     <= cfg_in;
      n_words_q <= CNT_W'(burst_words(cfg_in.set_sel, BANK_N));
    end
  end

  assign rd_word = slot_w[rd_idx];
endmodule

// File: rtl/stx_seq.sv
`timescale 1ns/1ps
// Burst sequencer: walks bits, packages and words; inserts gaps.
module stx_seq
  import stx_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned PKG_W     = 8,
  parameter int unsigned GAP_CELLS = 7,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cell_end,
  input  logic              gap_en,
  input  logic              byte_pkg,
  input  logic [CNT_W-1:0]  n_words,
  input  logic [WORD_W-1:0] cur_word,
  output logic              busy,
  output logic              shifting,
  output logic              in_gap,
  output logic [IDX_W-1:0]  word_idx,
  output logic              data_bit
);
  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam int unsigned GC_W  = (GAP_CELLS > 2) ? $clog2(GAP_CELLS) : 1;

  sq_state_e        state_q;
  logic [BIT_W-1:0] bit_q;
  logic [IDX_W-1:0] word_q;
  logic [GC_W-1:0]  gcnt_q;

  logic word_done;
  logic last_word;
  logic at_pkg_end;
  logic gap_done;

  assign word_done  = (bit_q == BIT_W'(WORD_W - 1));
  assign last_word  = (CNT_W'(word_q) == (n_words - CNT_W'(1)));
  assign at_pkg_end = pkg_last(byte_pkg, 32'(bit_q), PKG_W, WORD_W);
  assign gap_done   = (gcnt_q == GC_W'(GAP_CELLS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      bit_q   <= '0;
      word_q  <= '0;
      gcnt_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            state_q <= SQ_SHIFT;
            bit_q   <= '0;
            word_q  <= '0;
          end
        end
        SQ_SHIFT: begin
          if (cell_end) begin
            if (word_done && last_word) begin
              state_q <= SQ_IDLE;
              bit_q   <= '0;
              word_q  <= '0;
            end else begin
              if (word_done) begin
                bit_q  <= '0;
                word_q <= word_q + 1'b1;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
              if (gap_en && at_pkg_end) begin
                state_q <= SQ_GAP;
                gcnt_q  <= '0;
              end
            end
          end
        end
        SQ_GAP: begin
          if (cell_end) begin
            if (gap_done) begin
              state_q <= SQ_SHIFT;
              gcnt_q  <= '0;
            end else begin
              gcnt_q <= gcnt_q + 1'b1;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != SQ_IDLE);
  assign shifting = (state_q == SQ_SHIFT);
  assign in_gap   = (state_q == SQ_GAP);
  assign word_idx = word_q;
  assign data_bit = cur_word[BIT_W'(WORD_W - 1) - bit_q];
endmodule

// File: rtl/stream_tx_master.sv
`timescale 1ns/1ps
// Top level: shadow store, bit-cell timer and sequencer; drives the pins.
module stream_tx_master
  import stx_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned BANK_N    = 16,
  parameter int unsigned PKG_W     = 8,
  parameter int unsigned GAP_CELLS = 7,
  parameter int unsigned FAST_DIV  = 2,
  parameter int unsigned SLOW_DIV  = 4,
  parameter int unsigned CV_BASE   = 0,
  parameter int unsigned PWR_BASE  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               cfg_i,
  input  logic                     port_en_i,
  input  logic                     trig_i,
  input  logic [BANK_N*WORD_W-1:0] words_i,
  output logic                     sclk_o,
  output logic                     sdata_o,
  output logic                     sel_o,
  output logic                     busy_o
);
  localparam int unsigned IDX_W = $clog2(BANK_N);
  localparam int unsigned CNT_W = $clog2(BANK_N + 1);

  stx_cfg_t          cfg_sh;
  logic [CNT_W-1:0]  n_words;
  logic [WORD_W-1:0] cur_word;
  logic [IDX_W-1:0]  word_idx;
  logic              start_evt;
  logic              seq_busy;
  logic              seq_shifting;
  logic              seq_gap;
  logic              data_bit;
  logic              cell_end;
  logic              low_half;

  // Start event: armed, idle and triggered
  assign start_evt = trig_i && port_en_i && !seq_busy;

  stx_shadow #(
    .WORD_W  (WORD_W),
    .BANK_N  (BANK_N),
    .CV_BASE (CV_BASE),
    .PWR_BASE(PWR_BASE),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (start_evt),
    .cfg_i    (cfg_i),
    .words_i  (words_i),
    .rd_idx   (word_idx),
    .cfg_q    (cfg_sh),
    .n_words_q(n_words),
    .rd_word  (cur_word)
  );

  stx_cellclk #(
    .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) u_cellclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (seq_busy),
    .slow    (cfg_sh.slow_clk),
    .cell_end(cell_end),
    .low_half(low_half)
  );

  stx_seq #(
    .WORD_W   (WORD_W),
    .PKG_W    (PKG_W),
    .GAP_CELLS(GAP_CELLS),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_evt),
    .cell_end (cell_end),
    .gap_en   (cfg_sh.gap_en),
    .byte_pkg (cfg_sh.byte_pkg),
    .n_words  (n_words),
    .cur_word (cur_word),
    .busy     (seq_busy),
    .shifting (seq_shifting),
    .in_gap   (seq_gap),
    .word_idx (word_idx),
    .data_bit (data_bit)
  );

  // Pins: clock low in the first half of a data cell, idle high elsewhere
  assign sclk_o  = !(seq_shifting && low_half);
  assign sdata_o = seq_shifting ? data_bit : 1'b1;
  assign sel_o   = seq_shifting ? cfg_sh.sel_high : !cfg_sh.sel_high;
  assign busy_o  = seq_busy;
endmodule

// File: rtl/stream_tx_master_chk.sv
`timescale 1ns/1ps
module stream_tx_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trig_i,
  input logic       port_en_i,
  input logic       sclk_o,
  input logic       sdata_o,
  input logic       sel_o,
  input logic       busy_o,
  input logic       shifting,
  input logic       in_gap,
  input logic [7:0] cfg_sh
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (sclk_o && sdata_o));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && port_en_i && trig_i) |=> (busy_o && shifting && !sclk_o));

  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !port_en_i) |=> !busy_o);

  p_fast_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_o) && !cfg_sh[0]) |=> sclk_o);

  p_slow_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_o) && cfg_sh[0]) |=> !sclk_o);

  p_data_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && $past(shifting) && sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  p_gap_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> (sclk_o && sdata_o && (sel_o != cfg_sh[5])));

  p_gap_needs_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> cfg_sh[2]);

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && trig_i) |=> $stable(cfg_sh));
endmodule

bind stream_tx_master stream_tx_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig_i   (trig_i),
  .port_en_i(port_en_i),
  .sclk_o   (sclk_o),
  .sdata_o  (sdata_o),
  .sel_o    (sel_o),
  .busy_o   (busy_o),
  .shifting (seq_shifting),
  .in_gap   (seq_gap),
  .cfg_sh   (cfg_sh)
);

// File: tb/stream_tx_master_tb_top.sv
`timescale 1ns/1ps
module stream_tx_master_tb_top;

  typedef struct packed {
    logic [7:0]  cfg;
    logic [7:0]  nw;
    logic [15:0] busy;
    logic [15:0] selc;
  } vec_t;

  // cfg, words, busy cycles D*(32N+7G), select-active cycles D*32N
  localparam vec_t VECS [10] = '{
    '{8'h00, 8'd16, 16'd1024, 16'd1024},  // R3 fast, R5 full set
    '{8'h01, 8'd16, 16'd2048, 16'd2048},  // R3 slow cell
    '{8'h06, 8'd16, 16'd1906, 16'd1024},  // R6 byte packages, 63 gaps
    '{8'h04, 8'd16, 16'd1234, 16'd1024},  // R6 word packages, 15 gaps
    '{8'h08, 8'd7,  16'd448,  16'd448 },  // R5 current/voltage set
    '{8'h10, 8'd9,  16'd576,  16'd576 },  // R5 power set
    '{8'h18, 8'd16, 16'd1024, 16'd1024},  // R5 code 11 as 00
    '{8'h20, 8'd16, 16'd1024, 16'd1024},  // R8 active-high select
    '{8'hC2, 8'd16, 16'd1024, 16'd1024},  // R12 reserved set, R7 size without gap
    '{8'h2F, 8'd7,  16'd1652, 16'd896 }   // R3 R6 R8 combined
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   cfg_i = 8'h00;
  logic         port_en_i = 1'b0;
  logic         trig_i = 1'b0;
  logic [31:0]  bank [16];
  logic [511:0] words_i;
  logic         sclk_o, sdata_o, sel_o, busy_o;

  int n_chk = 0;
  int n_fail = 0;
  int busy_cnt = 0;
  int sel_cnt = 0;
  int rx_bits = 0;
  int stab_err = 0;
  logic [31:0] rx_mem [16];
  logic exp_pol = 1'b0;
  logic p_sclk = 1'b1;
  logic p_sdata = 1'b1;
  logic p_act = 1'b0;

  always #10 clk = ~clk;

  always_comb begin
    for (int k = 0; k < 16; k++) words_i[k*32 +: 32] = bank[k];
  end

  stream_tx_master dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_i    (cfg_i),
    .port_en_i(port_en_i),
    .trig_i   (trig_i),
    .words_i  (words_i),
    .sclk_o   (sclk_o),
    .sdata_o  (sdata_o),
    .sel_o    (sel_o),
    .busy_o   (busy_o)
  );

  // Line monitor, sampled mid-cycle
  always @(negedge clk) begin
    logic act;
    act = busy_o && (sel_o == exp_pol);
    if (busy_o) busy_cnt++;
    if (act) sel_cnt++;
    if (!p_sclk && sclk_o) begin
      if (rx_bits < 512) rx_mem[rx_bits/32] = {rx_mem[rx_bits/32][30:0], sdata_o};
      rx_bits++;
    end
    if (p_sclk && sclk_o && p_act && act && (sdata_o != p_sdata)) stab_err++;
    p_sclk = sclk_o;
    p_sdata = sdata_o;
    p_act = act;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] b [16], input logic [1:0] st, input int w);
    if (st == 2'b01) return (w < 6) ? b[w] : 32'h0;
    if (st == 2'b10) return (w < 6) ? b[w + 6] : 32'h0;
    return b[w];
  endfunction

  // mode 0: plain, 1: retrigger while busy, 2: change inputs mid-burst
  task automatic run_burst(input logic [7:0] c, input int mode, input int nw,
                           input int bcyc, input int scyc);
    logic [31:0] snap [16];
    logic [31:0] w0;
    logic [31:0] bad_act, bad_exp;
    logic [1:0]  st;
    int cnt, post, bad;
    cfg_i = c;
    exp_pol = c[5];
    st = c[4:3];
    @(posedge clk); #1;
    for (int k = 0; k < 16; k++) snap[k] = bank[k];
    w0 = exp_word(snap, st, 0);
    trig_i = 1'b1;
    busy_cnt = 0; sel_cnt = 0; rx_bits = 0; stab_err = 0;
    @(posedge clk); #1;
    trig_i = 1'b0;
    @(negedge clk);
    // R2: one cycle after the sampling edge
    chk(busy_o && !sclk_o && (sel_o == c[5]) && (sdata_o == w0[31]),
        "R2 burst start levels", {busy_o, sclk_o, sel_o, sdata_o}, {1'b1, 1'b0, c[5], w0[31]});
    cnt = 0;
    while (busy_o && cnt < 20000) begin
      @(negedge clk);
      cnt++;
      if (mode == 1 && cnt == 60) trig_i = 1'b1;
      if (mode == 1 && cnt == 61) trig_i = 1'b0;
      if (mode == 2 && cnt == 60) begin
        cfg_i = 8'h07;
        for (int k = 0; k < 16; k++) bank[k] = ~bank[k];
      end
    end
    chk(cnt < 20000, "R9 busy never fell", cnt, bcyc);
    chk(busy_cnt == bcyc, "R9 busy length (R3 cell, R6/R7 gaps)", busy_cnt, bcyc);
    chk(sel_cnt == scyc, "R8 select active cycles", sel_cnt, scyc);
    chk(rx_bits == nw * 32, "R5 received bit count", rx_bits, nw * 32);
    bad = 0; bad_act = '0; bad_exp = '0;
    for (int w = 0; w < nw; w++) begin
      if (rx_mem[w] !== exp_word(snap, st, w)) begin
        if (bad == 0) begin bad_act = rx_mem[w]; bad_exp = exp_word(snap, st, w); end
        bad++;
      end
    end
    chk(bad == 0, "R5 word contents MSB first (R11 shadow)", bad_act, bad_exp);
    chk(stab_err == 0, "R4 data moved while clock high", stab_err, 0);
    chk(sclk_o && sdata_o && (sel_o == !c[5]), "R8 idle levels after burst",
        {sclk_o, sdata_o, sel_o}, {1'b1, 1'b1, !c[5]});
    if (mode == 1) begin
      post = 0;
      repeat (30) begin
        @(negedge clk);
        if (busy_o) post++;
      end
      chk(post == 0, "R10 retrigger while busy ignored", post, 0);
    end
    if (mode == 2) begin
      cfg_i = c;
      for (int k = 0; k < 16; k++) bank[k] = snap[k];
    end
  endtask

  initial begin
    for (int k = 0; k < 16; k++)
      bank[k] = {8'(8'hA0 + k), 8'(k * 17), 8'(8'h5C ^ k), 8'(8'hFF - k * 9)};
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(sclk_o && sdata_o && sel_o && !busy_o, "R1 levels in reset",
        {sclk_o, sdata_o, sel_o, busy_o}, 4'b1110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk_o && sdata_o && sel_o && !busy_o, "R1 levels after reset",
        {sclk_o, sdata_o, sel_o, busy_o}, 4'b1110);

    // R2: trigger with port disabled
    @(posedge clk); #1;
    trig_i = 1'b1; busy_cnt = 0; rx_bits = 0;
    @(posedge clk); #1;
    trig_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy_cnt == 0 && rx_bits == 0 && sel_o, "R2 trigger ignored while disabled",
        busy_cnt + rx_bits, 0);

    port_en_i = 1'b1;
    for (int v = 0; v < 10; v++) begin
      for (int k = 0; k < 16; k++) bank[k] = bank[k] ^ {4{8'(v * 29)}};
      run_burst(VECS[v].cfg, 0, int'(VECS[v].nw), int'(VECS[v].busy), int'(VECS[v].selc));
    end
    run_burst(8'h00, 1, 16, 1024, 1024);   // R10
    run_burst(8'h08, 2, 7, 448, 448);      // R11
    run_burst(8'h20, 2, 16, 1024, 1024);   // R11 with active-high select

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired R9 actual=%0d expected=0", busy_cnt);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule